// File: doc/BRIEF.md
# Timer Compare-Output Waveform Unit

An 8-bit up-counter with a single output-compare channel that shapes a waveform pin. A control register holds a wave-mode field (free-running, clear-on-compare, or fast PWM), a top-select bit and a two-bit output-action code. A compare register supplies the match value. Each cycle the block decides whether the counter has hit the compare value, whether it has reached its TOP value, and what the waveform flop does as a result. It also drives an ownership flag that tells the surrounding pin multiplexer whether the timer is driving the pin.

Software-style writes arrive on a plain strobe interface. `wr_sel` = 0 selects the control register and `wr_sel` = 1 selects the compare register. In fast PWM a compare write is held in a shadow copy and only reaches the live comparator when the counter wraps. This keeps a PWM period from being cut short.

Top module: `tmr_ocu`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `cnt`, `wave_out` and `pin_own` read 0, and all control fields and both compare copies are 0.
- R2: `pin_own` is 1 exactly when the action code is nonzero, except for code 01 in fast PWM with the top-select bit 0. While `pin_own` is 0, `wave_out` keeps its value.
- R3: In free-running and clear-on-compare modes, a cycle in which `cnt` equals the live compare value makes `wave_out` act at the next clock edge: code 01 inverts it, 10 drives it to 0 and 11 drives it to 1.
- R4: In fast PWM, code 01 with top-select 1 inverts `wave_out` after each compare match. With top-select 0 the pin is released and `wave_out` holds.
- R5: In fast PWM, code 10 drives `wave_out` to 0 after a match and to 1 after the cycle in which `cnt` is at TOP.
- R6: In fast PWM, code 11 drives `wave_out` to 1 after a match and to 0 after the cycle at TOP.
- R7: In fast PWM with codes 10 or 11, when the compare value equals TOP, the match is ignored and only the TOP action is applied.
- R8: TOP is 0xFF in free-running mode and in fast PWM with top-select 0. It is the live compare value in clear-on-compare mode and in fast PWM with top-select 1. In the cycle after `cnt` equals TOP, `cnt` is 0; otherwise it increments by one modulo 256.
- R9: In clear-on-compare mode `cnt` restarts from 0 after reaching the compare value. If the compare value is written below the current count, `cnt` runs on through 0xFF before it matches.
- R10: In fast PWM, a compare write lands in a shadow copy and reaches the live compare value only at the edge that ends a cycle in which `cnt` is at TOP. In the other modes it takes effect at the next edge.
- R11: The control word packs the action code in bits [1:0], the wave mode in [3:2] (00 free-running, 01 clear-on-compare, 10 fast PWM, 11 behaves as free-running) and top-select in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: control word, 1: compare value |
| wr_data | input | 8 | Write data |
| cnt | output | 8 | Current counter value |
| wave_out | output | 1 | Registered waveform output |
| pin_own | output | 1 | Timer owns the pin |

## Verification
The bench sweeps every wave mode, top-select value and action code against compare values 0x00, 0x40 and 0xFF. Partway through each run it rewrites the compare value. A design that let the match win when the compare value equals TOP would collapse a 0xFF duty to a one-cycle glitch, or hold the pin stuck in the inverted sense. A compare value of 0 in clear-on-compare mode pins the counter at zero, and the output must then toggle on every clock. A rewrite below the running count must send the counter the long way round through 0xFF. A design without the PWM shadow copy would shorten the period in progress, and the wave trace would diverge before the next wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    WM_FREE = 2'b00,
    WM_CTC  = 2'b01,
    WM_FAST = 2'b10,
    WM_RSVD = 2'b11
  } wmode_t;

  localparam logic [1:0] OA_OFF = 2'b00;
  localparam logic [1:0] OA_TGL = 2'b01;
  localparam logic [1:0] OA_CLR = 2'b10;
  localparam logic [1:0] OA_SET = 2'b11;

  localparam int CTRL_OA_LSB = 0;
  localparam int CTRL_WM_LSB = 2;
  localparam int CTRL_TS_BIT = 4;
endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         at_top,
  output logic [1:0]   oact,
  output wmode_t       wmode,
  output logic         tsel,
  output logic [W-1:0] cmp_live
);
  logic [1:0]   wm_raw;
  logic [W-1:0] cmp_shadow;
  logic         is_pwm;

  // reserved code folds onto free-running
  assign wmode  = (wm_raw == WM_RSVD) ? WM_FREE : wmode_t'(wm_raw);
  assign is_pwm = (wmode == WM_FAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      oact       <= OA_OFF;
      wm_raw     <= 2'b00;
      tsel       <= 1'b0;
      cmp_shadow <= '0;
      cmp_live   <= '0;
    end else begin
      if (wr_en && !wr_sel) begin
        oact   <= wr_data[CTRL_OA_LSB +: 2];
        wm_raw <= wr_data[CTRL_WM_LSB +: 2];
        tsel   <= wr_data[CTRL_TS_BIT];
      end
      if (wr_en && wr_sel) cmp_shadow <= wr_data;
      if (is_pwm && at_top)              cmp_live <= cmp_shadow;
      else if (wr_en && wr_sel && !is_pwm) cmp_live <= wr_data;
    end
  end

  assert_reset_cfg_R1: assert property (@(posedge clk)
    rst |=> (oact == OA_OFF && wm_raw == 2'b00 && !tsel && cmp_live == '0));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && !at_top) |=> $stable(cmp_live));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  wmode_t       wmode,
  input  logic         tsel,
  input  logic [W-1:0] cmp_live,
  output logic [W-1:0] cnt,
  output logic         at_top,
  output logic         match
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         top_is_cmp;
  logic [W-1:0] top_val;

  assign top_is_cmp = (wmode == WM_CTC) || (wmode == WM_FAST && tsel);
  assign top_val    = top_is_cmp ? cmp_live : MAXV;
  assign at_top     = (cnt == top_val);
  assign match      = (cnt == cmp_live);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (at_top) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assert_wrap_at_top_R8: assert property (@(posedge clk) disable iff (rst)
    at_top |=> (cnt == '0));

  assert_step_R9: assert property (@(posedge clk) disable iff (rst)
    !at_top |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wmode_t     wmode,
  input  logic       tsel,
  input  logic [1:0] oact,
  input  logic       at_top,
  input  logic       match,
  output logic       wave,
  output logic       own
);
  logic is_pwm;
  logic wave_d;

  assign is_pwm = (wmode == WM_FAST);
  assign own    = (oact != OA_OFF) && !(is_pwm && oact == OA_TGL && !tsel);

  always_comb begin
    wave_d = wave;
    if (!is_pwm) begin
      if (match) begin
        unique case (oact)
          OA_TGL:  wave_d = !wave;
          OA_CLR:  wave_d = 1'b0;
          OA_SET:  wave_d = 1'b1;
          default: wave_d = wave;
        endcase
      end
    end else begin
      unique case (oact)
        OA_TGL: if (tsel && match) wave_d = !wave;
        OA_CLR: begin
          if (at_top)     wave_d = 1'b1;  // TOP action wins over a coincident match
          else if (match) wave_d = 1'b0;
        end
        OA_SET: begin
          if (at_top)     wave_d = 1'b0;
          else if (match) wave_d = 1'b1;
        end
        default: wave_d = wave;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b0;
    else     wave <= wave_d;
  end

  assert_reset_wave_R1: assert property (@(posedge clk)
    rst |=> !wave);

  assert_nonpwm_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (!is_pwm && oact == OA_CLR && match) |=> !wave);

  assert_inverting_top_R6: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && oact == OA_SET && at_top) |=> !wave);

  assert_top_beats_match_R7: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && oact == OA_CLR && at_top && match) |=> wave);

  assert_released_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !own |=> $stable(wave));
endmodule

// File: rtl/tmr_ocu.sv
module tmr_ocu
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic         wave_out,
  output logic         pin_own
);
  logic [1:0]   oact;
  wmode_t       wmode;
  logic         tsel;
  logic [W-1:0] cmp_live;
  logic         at_top;
  logic         match;

  tmr_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .at_top(at_top), .oact(oact), .wmode(wmode), .tsel(tsel), .cmp_live(cmp_live)
  );

  tmr_count #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .wmode(wmode), .tsel(tsel), .cmp_live(cmp_live),
    .cnt(cnt), .at_top(at_top), .match(match)
  );

  tmr_wave u_wave (
    .clk(clk), .rst(rst), .wmode(wmode), .tsel(tsel), .oact(oact),
    .at_top(at_top), .match(match), .wave(wave_out), .own(pin_own)
  );
endmodule

// File: tb/sim_tmr_ocu.sv
module sim_tmr_ocu;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cnt;
  logic       wave_out, pin_own;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit chk_en = 1'b0;

  tmr_ocu u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt(cnt), .wave_out(wave_out), .pin_own(pin_own)
  );

  // reference model built from the requirements
  logic [1:0] m_oa, m_md;
  logic       m_ts, m_wave, m_pend;
  logic [7:0] m_shadow, m_live, m_cnt;

  always @(posedge clk) begin : mdl
    logic [1:0] wm;
    logic       pwm, attop, mt;
    logic [7:0] top;
    if (rst) begin
      m_oa <= 0; m_md <= 0; m_ts <= 0; m_wave <= 0; m_pend <= 0;
      m_shadow <= 0; m_live <= 0; m_cnt <= 0;
    end else begin
      wm    = (m_md == 2'd3) ? 2'd0 : m_md;          // R11
      pwm   = (wm == 2'd2);
      top   = (wm == 2'd1 || (pwm && m_ts)) ? m_live : 8'hFF;  // R8
      attop = (m_cnt == top);
      mt    = (m_cnt == m_live);
      m_cnt <= attop ? 8'h00 : m_cnt + 8'h01;
      if (!pwm) begin
        if (mt) begin
          if (m_oa == 2'd1) m_wave <= !m_wave;
          else if (m_oa == 2'd2) m_wave <= 1'b0;
          else if (m_oa == 2'd3) m_wave <= 1'b1;
        end
      end else if (m_oa == 2'd1) begin
        if (m_ts && mt) m_wave <= !m_wave;
      end else if (m_oa[1]) begin
        if (attop) m_wave <= (m_oa == 2'd2);
        else if (mt) m_wave <= (m_oa == 2'd3);
      end
      if (pwm && attop) begin m_live <= m_shadow; m_pend <= 1'b0; end
      if (wr_en && !wr_sel) begin
        m_oa <= wr_data[1:0]; m_md <= wr_data[3:2]; m_ts <= wr_data[4];
      end
      if (wr_en && wr_sel) begin
        m_shadow <= wr_data;
        if (!pwm) m_live <= wr_data;
        else m_pend <= 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string wave_tag();
    logic [1:0] wm;
    wm = (m_md == 2'd3) ? 2'd0 : m_md;
    if (m_md == 2'd3) return "R11";
    if (wm != 2'd2) return "R3";
    if (m_pend) return "R10";
    if (m_oa == 2'd0) return "R2";
    if (m_oa == 2'd1) return "R4";
    if (m_ts || m_live == 8'hFF) return "R7";
    if (m_oa == 2'd2) return "R5";
    return "R6";
  endfunction

  always begin
    @(posedge clk);
    #5;
    if (chk_en) begin : cyc
      logic exp_own;
      exp_own = (m_oa != 2'd0) && !(m_md == 2'd2 && m_oa == 2'd1 && !m_ts);
      chk((m_md == 2'd1) ? "R9" : "R8", cnt, m_cnt);
      chk(wave_tag(), {7'd0, wave_out}, {7'd0, m_wave});
      chk("R2", {7'd0, pin_own}, {7'd0, exp_own});
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_cfg(input logic [1:0] md, input logic ts,
                         input logic [1:0] oa, input logic [7:0] cv);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", cnt, 8'h00);
    chk("R1", {7'd0, wave_out}, 8'h00);
    chk("R1", {7'd0, pin_own}, 8'h00);
    wr(1'b0, {3'b000, ts, md, oa});
    wr(1'b1, cv);
    repeat (300) @(negedge clk);
    wr(1'b1, cv + 8'h90);                 // mid-run rewrite, R10 and R9
    repeat (300) @(negedge clk);
  endtask

  initial begin
    logic [7:0] cvals [3];
    cvals[0] = 8'h00; cvals[1] = 8'h40; cvals[2] = 8'hFF;
    repeat (2) @(negedge clk);
    chk_en = 1'b1;
    for (int md = 0; md < 4; md++)
      for (int ts = 0; ts < 2; ts++)
        for (int oa = 0; oa < 4; oa++)
          for (int k = 0; k < 3; k++)
            run_cfg(md[1:0], ts[0], oa[1:0], cvals[k]);
    chk_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(64'd200000 * 64'd20);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule